// File: doc/BRIEF.md
# Timer-Paired Watchdog with Staged Expiry

This block is a watchdog peripheral fed by its own periodic timer channel. The timer divides a one-microsecond tick-enable into expiry pulses. The watchdog counts those pulses down from a programmed period. Every time the count runs out, the block records an expiration and reloads. The system reset request goes out only on the fourth expiration in a row. Software keeps the system alive by sending a start/ping command before that happens. Each ping reloads the countdown and clears the expiration count.

Software uses a small write/read register port. Config, status, command and unlock registers sit at offsets 0x0, 0x4, 0x8 and 0xC. The timer's control word sits at 0x10. Stopping the watchdog needs a key written to the unlock register first. Each command write uses up the unlock, so a stray disable cannot stop the watchdog.

Top module: `wdt_timer_paired`

## Requirements
- R1: After reset, the config, status and timer registers all read 0, irqPulse and sysResetReq are low, the watchdog is stopped and the unlock is cleared.
- R2: The timer word at offset 0x10 holds the reload count in bits [29:0], periodic mode in bit 30 and enable in bit 31, and it reads back as written. While enabled, the timer produces one expiry every `reload` rising tickUs cycles (a reload of 0 acts as 1). Writing 0 stops the timer.
- R3: When bit 30 is clear (one-shot mode), the timer produces a single expiry and then clears its own enable bit, which reads back as 0.
- R4: The config word at offset 0x0 has these fields: timer select in bits [3:0] (stored only), watchdog period in bits [11:4], interrupt enable in bit 12 and reset enable in bit 15. All other bits read 0.
- R5: A command write at offset 0x8 with bit 0 set starts or pings the watchdog. It loads the count from the period, clears the expiration count to 0 and sets the watchdog running.
- R6: While the watchdog runs, each timer expiry decrements the count by one. When the count reaches zero, the expiration count increments and the count reloads from the period. The status word at offset 0x4 shows the count in bits [11:4] and the expiration count in bits [13:12].
- R7: When interrupt enable is set, irqPulse is high for exactly one cycle on each expiration, including the fourth.
- R8: On the fourth consecutive expiration, sysResetReq is high for one cycle, but only if reset enable is set. The expiration count then returns to 0 and counting continues.
- R9: Command bit 1 stops the watchdog only if the immediately preceding unlock write was 0x0000C45A at offset 0xC. Otherwise the disable is ignored. If both command bits are set and the unlock is valid, the stop wins.
- R10: Any command write clears the unlock, whatever its value. An unlock write with any other value also clears it.
- R11: While the watchdog is stopped, timer expiries leave the count and the expiration count unchanged and produce no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-microsecond tick enable for the timer channel |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte offset |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational from busAddr) |
| irqPulse | output | 1 | One-cycle interrupt on each expiration |
| sysResetReq | output | 1 | One-cycle system reset request on the fourth expiration |

## Verification
The assertions check several rules on every cycle:
- a reset request appears only where the expiration count wraps from three to zero, and lasts a single cycle;
- an interrupt always follows a timer expiry seen while the watchdog was running;
- a start reloads the count and clears the expiration count;
- the watchdog stops only through an accepted disable, and its state stays frozen while it is stopped;
- a command write always consumes the unlock;
- a one-shot expiry always leaves the timer disabled.

Only the bench scenarios can show the behaviour that depends on sequences of register traffic. This covers:
- the exact count sequence across all four expirations;
- the period of a multi-tick timer reload;
- a disable being ignored after a wrong key or after an intervening command write;
- the interrupt and reset enables gating their pulses independently.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int PERIOD_W  = 8;
  localparam int EXP_LIMIT = 4;
  localparam int EXP_W     = $clog2(EXP_LIMIT);

  localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_UNLOCK = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TMR    = 5'h10;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

  localparam int CFG_PERIOD_LSB = 4;
  localparam int CFG_IRQ_BIT    = 12;
  localparam int CFG_RST_BIT    = 15;
  localparam int STS_COUNT_LSB  = 4;
  localparam int STS_EXP_LSB    = 12;
  localparam int CMD_START_BIT  = 0;
  localparam int CMD_STOP_BIT   = 1;
  localparam int TMR_PER_BIT    = 30;
  localparam int TMR_EN_BIT     = 31;

  typedef struct packed {
    logic start;
    logic stop;
    logic expiry;
  } wdt_strobe_t;

  typedef struct packed {
    logic [PERIOD_W-1:0] period;
    logic                irqEn;
    logic                rstEn;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_tick_timer.sv
module wdt_tick_timer
  import wdt_pkg::*;
#(
  parameter int RELOAD_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickUs,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              expiry
);
  localparam int PAD_W = TMR_PER_BIT - RELOAD_W;

  logic [RELOAD_W-1:0] reloadVal;
  logic [RELOAD_W-1:0] tickCnt;
  logic                periodic;
  logic                enable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      tickCnt   <= '0;
      periodic  <= 1'b0;
      enable    <= 1'b0;
      expiry    <= 1'b0;
    end else if (wrEn) begin
      reloadVal <= wrData[RELOAD_W-1:0];
      tickCnt   <= wrData[RELOAD_W-1:0];
      periodic  <= wrData[TMR_PER_BIT];
      enable    <= wrData[TMR_EN_BIT];
      expiry    <= 1'b0;
    end else if (enable && tickUs) begin
      if (tickCnt <= RELOAD_W'(1)) begin
        expiry  <= 1'b1;
        tickCnt <= reloadVal;
        if (!periodic) enable <= 1'b0;
      end else begin
        expiry  <= 1'b0;
        tickCnt <= tickCnt - RELOAD_W'(1);
      end
    end else begin
      expiry <= 1'b0;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctrlWord = {enable, periodic, {PAD_W{1'b0}}, reloadVal};
    end else begin : g_nopad
      assign ctrlWord = {enable, periodic, reloadVal};
    end
  endgenerate

  p_expiry_from_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    expiry |-> $past(tickUs));

  p_oneshot_stops_r3: assert property (@(posedge clk) disable iff (!rstN)
    (expiry && !periodic) |-> !enable);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [PERIOD_W-1:0] stsCount,
  input  logic [EXP_W-1:0]    stsExp,
  input  logic [DATA_W-1:0]   tmrWord,
  output wdt_cfg_t            cfg,
  output logic                cmdStart,
  output logic                cmdStop,
  output logic                tmrWr,
  output logic [DATA_W-1:0]   busRdData
);
  logic [3:0] timerSel;
  logic       unlocked;
  logic       cfgWr;
  logic       cmdWr;
  logic       unlockWr;

  assign cfgWr    = busWrEn && (busAddr == OFS_CFG);
  assign cmdWr    = busWrEn && (busAddr == OFS_CMD);
  assign unlockWr = busWrEn && (busAddr == OFS_UNLOCK);
  assign tmrWr    = busWrEn && (busAddr == OFS_TMR);

  assign cmdStop  = cmdWr && busWrData[CMD_STOP_BIT] && unlocked;
  assign cmdStart = cmdWr && busWrData[CMD_START_BIT] && !cmdStop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      timerSel <= '0;
      unlocked <= 1'b0;
    end else begin
      if (cfgWr) begin
        timerSel   <= busWrData[3:0];
        cfg.period <= busWrData[CFG_PERIOD_LSB +: PERIOD_W];
        cfg.irqEn  <= busWrData[CFG_IRQ_BIT];
        cfg.rstEn  <= busWrData[CFG_RST_BIT];
      end
      if (unlockWr)   unlocked <= (busWrData == UNLOCK_KEY);
      else if (cmdWr) unlocked <= 1'b0;
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_CFG: begin
        busRdData[3:0]                       = timerSel;
        busRdData[CFG_PERIOD_LSB +: PERIOD_W] = cfg.period;
        busRdData[CFG_IRQ_BIT]               = cfg.irqEn;
        busRdData[CFG_RST_BIT]               = cfg.rstEn;
      end
      OFS_STS: begin
        busRdData[STS_COUNT_LSB +: PERIOD_W] = stsCount;
        busRdData[STS_EXP_LSB +: EXP_W]      = stsExp;
      end
      OFS_TMR: busRdData = tmrWord;
      default: busRdData = '0;
    endcase
  end

  p_unlock_consumed_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdWr) |-> !unlocked);

  p_stop_needs_key_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |-> $past(unlockWr || !busWrEn || (busAddr != OFS_CMD)));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  wdt_strobe_t         strb,
  input  wdt_cfg_t            cfg,
  output logic [PERIOD_W-1:0] count,
  output logic [EXP_W-1:0]    expCnt,
  output logic                irqPulse,
  output logic                rstReq
);
  localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(EXP_LIMIT - 1);

  logic running;
  logic lastStage;

  assign lastStage = (expCnt == EXP_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      count    <= '0;
      expCnt   <= '0;
      irqPulse <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      rstReq   <= 1'b0;
      if (strb.stop) begin
        running <= 1'b0;
      end else if (strb.start) begin
        running <= 1'b1;
        count   <= cfg.period;
        expCnt  <= '0;
      end else if (running && strb.expiry) begin
        if (count <= PERIOD_W'(1)) begin
          count    <= cfg.period;
          irqPulse <= cfg.irqEn;
          if (lastStage) begin
            expCnt <= '0;
            rstReq <= cfg.rstEn;
          end else begin
            expCnt <= expCnt + EXP_W'(1);
          end
        end else begin
          count <= count - PERIOD_W'(1);
        end
      end
    end
  end

  p_rst_on_last_stage_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (expCnt == '0) && ($past(expCnt) == EXP_LAST));

  p_rst_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  p_irq_from_expiry_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strb.expiry) && $past(running));

  p_start_reloads_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.start) |-> (count == $past(cfg.period)) && (expCnt == '0) && running);

  p_stop_only_by_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(strb.stop));

  p_frozen_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.start) |=> $stable(count) && $stable(expCnt) && !irqPulse && !rstReq);
endmodule

// File: rtl/wdt_timer_paired.sv
module wdt_timer_paired
  import wdt_pkg::*;
#(
  parameter int RELOAD_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickUs,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqPulse,
  output logic              sysResetReq
);
  wdt_cfg_t            cfg;
  wdt_strobe_t         strb;
  logic                cmdStart;
  logic                cmdStop;
  logic                tmrWr;
  logic                tmrExpiry;
  logic [DATA_W-1:0]   tmrWord;
  logic [PERIOD_W-1:0] count;
  logic [EXP_W-1:0]    expCnt;

  assign strb = '{start: cmdStart, stop: cmdStop, expiry: tmrExpiry};

  wdt_tick_timer #(.RELOAD_W(RELOAD_W)) u_timer (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .wrEn(tmrWr),
    .wrData(busWrData), .ctrlWord(tmrWord), .expiry(tmrExpiry)
  );

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .stsCount(count), .stsExp(expCnt),
    .tmrWord(tmrWord), .cfg(cfg), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .tmrWr(tmrWr), .busRdData(busRdData)
  );

  wdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .count(count),
    .expCnt(expCnt), .irqPulse(irqPulse), .rstReq(sysResetReq)
  );
endmodule

// File: tb/wdt_timer_paired_bench.sv
`timescale 1ns/1ps
module wdt_timer_paired_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickUs = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqPulse;
  logic        sysResetReq;

  int checks = 0;
  int errors = 0;

  logic [1:0] evQ[$];

  // reference model state, written from the requirements
  int  mReload = 0, mTcnt = 0;
  bit  mTEn = 0, mTPer = 0;
  int  mPeriod = 0, mCnt = 0, mExp = 0;
  bit  mIrqEn = 0, mRstEn = 0, mRun = 0, mUnl = 0;

  always #2.5 clk = ~clk;

  wdt_timer_paired u_wdt_timer_paired (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqPulse(irqPulse), .sysResetReq(sysResetReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      5'h10: begin mReload = d[29:0]; mTcnt = d[29:0]; mTPer = d[30]; mTEn = d[31]; end
      5'h00: begin mPeriod = d[11:4]; mIrqEn = d[12]; mRstEn = d[15]; end
      5'h0C: mUnl = (d == 32'h0000_C45A);
      5'h08: begin
        if (d[1] && mUnl) mRun = 0;
        else if (d[0]) begin mRun = 1; mCnt = mPeriod; mExp = 0; end
        mUnl = 0;
      end
      default: ;
    endcase
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic tickOnce();
    logic [1:0] ev;
    ev = 2'b00;
    if (mTEn) begin
      if (mTcnt <= 1) begin
        mTcnt = mReload;
        if (!mTPer) mTEn = 0;
        if (mRun) begin
          if (mCnt <= 1) begin
            mCnt = mPeriod;
            if (mExp == 3) begin mExp = 0; ev[1] = mRstEn; end
            else mExp = mExp + 1;
            ev[0] = mIrqEn;
          end else mCnt = mCnt - 1;
        end
      end else mTcnt = mTcnt - 1;
    end
    if (ev != 2'b00) evQ.push_back(ev);
    @(negedge clk); tickUs = 1'b1;
    @(negedge clk); tickUs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkStatus(input string tag);
    logic [31:0] d;
    regRead(5'h04, d);
    check(tag, d, {18'b0, mExp[1:0], mCnt[7:0], 4'b0});
  endtask

  // monitor: pops expected pulse items as the design produces them (R7, R8)
  always @(negedge clk) begin
    if (rstN && (irqPulse || sysResetReq)) begin
      if (evQ.size() == 0) check("R7/R8 unexpected pulse", {30'b0, sysResetReq, irqPulse}, 32'h0);
      else check("R7/R8 pulse {rst,irq}", {30'b0, sysResetReq, irqPulse}, {30'b0, evQ.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead(5'h00, d); check("R1 cfg", d, 32'h0);
    regRead(5'h04, d); check("R1 status", d, 32'h0);
    regRead(5'h10, d); check("R1 timer", d, 32'h0);
    check("R1 outputs", {30'b0, sysResetReq, irqPulse}, 32'h0);

    // R2 timer readback, reload 1 periodic
    regWrite(5'h10, 32'hC000_0001);
    regRead(5'h10, d); check("R2 timer readback", d, 32'hC000_0001);

    // R4 config with stray bits
    regWrite(5'h00, 32'h0000_F035);
    regRead(5'h00, d); check("R4 cfg readback", d, 32'h0000_9035);

    // R5 start
    regWrite(5'h08, 32'h1);
    checkStatus("R5 start loads period");

    // R6 R7 R8: four expirations of period 3
    for (int i = 0; i < 12; i++) begin tickOnce(); checkStatus("R6 countdown"); end

    // R5 ping mid-count
    tickOnce(); tickOnce(); tickOnce(); tickOnce();
    regWrite(5'h08, 32'h1);
    checkStatus("R5 ping reloads and clears");

    // R9 disable without unlock ignored
    regWrite(5'h08, 32'h2);
    tickOnce(); checkStatus("R9 locked disable ignored");

    // R10 wrong key
    regWrite(5'h0C, 32'h0000_1234);
    regWrite(5'h08, 32'h2);
    tickOnce(); checkStatus("R10 wrong key");

    // R10 unlock consumed by intervening command write
    regWrite(5'h0C, 32'h0000_C45A);
    regWrite(5'h08, 32'h0);
    regWrite(5'h08, 32'h2);
    tickOnce(); checkStatus("R10 unlock consumed");

    // R9 stop wins when both bits set; R11 frozen
    regWrite(5'h0C, 32'h0000_C45A);
    regWrite(5'h08, 32'h3);
    for (int i = 0; i < 5; i++) tickOnce();
    checkStatus("R11 frozen after stop");

    // R8 reset disabled: irq only
    regWrite(5'h00, 32'h0000_1010);
    regWrite(5'h08, 32'h1);
    for (int i = 0; i < 4; i++) tickOnce();
    checkStatus("R8 no reset when disabled");

    // R7 irq disabled, reset enabled
    regWrite(5'h00, 32'h0000_8020);
    regWrite(5'h08, 32'h1);
    for (int i = 0; i < 8; i++) tickOnce();
    checkStatus("R7 irq gated R8 reset");

    // R2 multi-tick reload 3
    regWrite(5'h00, 32'h0000_1010);
    regWrite(5'h10, 32'hC000_0003);
    regWrite(5'h08, 32'h1);
    for (int i = 0; i < 6; i++) begin tickOnce(); checkStatus("R2 reload 3"); end

    // R3 one-shot
    regWrite(5'h10, 32'h8000_0002);
    for (int i = 0; i < 4; i++) tickOnce();
    checkStatus("R3 one-shot single expiry");
    regRead(5'h10, d); check("R3 enable cleared", d, 32'h0000_0002);

    // R2 writing zero stops timer
    regWrite(5'h10, 32'hC000_0001);
    regWrite(5'h10, 32'h0);
    for (int i = 0; i < 3; i++) tickOnce();
    checkStatus("R2 timer stopped");

    repeat (5) @(negedge clk);
    check("R7/R8 all expected pulses seen", evQ.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule